// File: doc/BRIEF.md
# Pin Change Interrupt Generator

This block raises an interrupt request for a general-purpose I/O expander whose pins are grouped into byte-wide ports. Each port has an input register that holds the pin levels captured at its last read. Each port also has a direction setting per pin. The block compares the live levels of the pins set as inputs with that captured copy. While any such pin disagrees with its stored bit, the shared interrupt line is pulled low.

The condition is a level, not a latched edge. If a pin goes back to its stored value, the request drops without any read. A read of one port removes only that port's share of the request, so a pending change on another port keeps the line low. The comparison uses raw pin levels, before any polarity inversion, so inversion settings neither raise nor hide an interrupt. The pins pass through a synchronizer of at least two flops. The line-drive output comes straight from a flop, so it cannot glitch.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is active and in the first cycle after it, `irq_pull_o` is 0 (line released), given pins equal to the snapshot.
- R2: A pin whose `dir_in_i` bit is 1 (1 = input, 0 = output) and whose level differs from its `snap_i` bit sets `irq_pull_o` to 1 at the (SYNC_STAGES+1)-th rising edge after the pin changes.
- R3: When such a pin returns to its stored level, with no read in between, `irq_pull_o` returns to 0 SYNC_STAGES+1 edges later.
- R4: A read strobe `rd_stb_i[p]` sampled high at an edge clears port p's contribution at that edge. Port p is bits p*PORT_W to p*PORT_W+PORT_W-1 of the pin, direction and snapshot buses.
- R5: A read strobe on one port does not clear a pending mismatch of any other port: `irq_pull_o` stays 1 across that edge.
- R6: Pins whose `dir_in_i` bit is 0 never cause `irq_pull_o` to go to 1, whatever their levels.
- R7: Changing a pin's `dir_in_i` bit from 0 to 1 while its synchronized level differs from its `snap_i` bit sets `irq_pull_o` to 1 at the next rising edge. This change is not masked.
- R8: `irq_pull_o` is an open-drain enable: 1 means the active-low line is pulled low, and 0 means it is released. It is 1 exactly when at least one port holds a pending mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | PORT_W*NUM_PORTS | Raw pin levels, asynchronous |
| dir_in_i | input | PORT_W*NUM_PORTS | Direction per pin, 1 = input |
| snap_i | input | PORT_W*NUM_PORTS | Stored input register contents of all ports |
| rd_stb_i | input | NUM_PORTS | One-cycle read strobe per port input register |
| irq_pull_o | output | 1 | Open-drain enable for the active-low interrupt line |

## Verification
The bench builds the block with two ports of eight pins and a two-stage synchronizer. Two ports make the cross-port cases reachable: a read of the first port while the second still disagrees, and the reverse. With two sync stages, the three-edge delay from a pin change to the line can be checked at an exact cycle. Direction switching is done with already-settled pins. This isolates the single-edge path from direction to line, separate from the synchronizer path.

// File: rtl/pcirq_pkg.sv
package pcirq_pkg;
   localparam int unsigned DEF_PORT_W   = 8;
   localparam int unsigned DEF_PORTS    = 2;
   localparam int unsigned DEF_SYNC     = 2;
   localparam int unsigned MIN_SYNC     = 2;

   // per-pin direction encoding
   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } pin_dir_e;
endpackage

// File: rtl/pcirq_sync.sv
module pcirq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2,
   parameter logic        RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= {WIDTH{RST_LVL}};
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= {WIDTH{RST_LVL}};
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcirq_port_cmp.sv
module pcirq_port_cmp
   import pcirq_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_s_i,
   input  logic [WIDTH-1:0] snap_i,
   input  logic [WIDTH-1:0] dir_i,
   input  logic             rd_i,
   output logic             pend_d_o,
   output logic             pend_q_o
);
   logic [WIDTH-1:0] live_mask;
   logic [WIDTH-1:0] diff;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         assign live_mask[b] = (pin_dir_e'(dir_i[b]) == DIR_IN);
      end
   endgenerate

   assign diff     = (pin_s_i ^ snap_i) & live_mask;
   assign pend_d_o = rd_i ? 1'b0 : (|diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q_o <= 1'b0;
      else        pend_q_o <= pend_d_o;
   end

   // R4: a read strobe empties this port's share at that edge
   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> !pend_q_o);

   // R6: a port with every pin as output never holds a pending flag
   p_outputs_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_i == '0) |=> !pend_q_o);

   // R2: an unread input mismatch becomes pending at the next edge
   p_mismatch_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && ((pin_s_i & dir_i) != (snap_i & dir_i))) |=> pend_q_o);
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
   import pcirq_pkg::*;
#(
   parameter int unsigned PORT_W      = DEF_PORT_W,
   parameter int unsigned NUM_PORTS   = DEF_PORTS,
   parameter int unsigned SYNC_STAGES = DEF_SYNC,
   localparam int unsigned TOT_W      = PORT_W * NUM_PORTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [TOT_W-1:0]     pin_i,
   input  logic [TOT_W-1:0]     dir_in_i,
   input  logic [TOT_W-1:0]     snap_i,
   input  logic [NUM_PORTS-1:0] rd_stb_i,
   output logic                 irq_pull_o
);
   generate
      if (SYNC_STAGES < MIN_SYNC) begin : g_bad_sync
         $error("pin_change_irq: SYNC_STAGES must be at least %0d", MIN_SYNC);
      end
      if (PORT_W == 0 || NUM_PORTS == 0) begin : g_bad_shape
         $error("pin_change_irq: PORT_W and NUM_PORTS must be nonzero");
      end
   endgenerate

   logic [TOT_W-1:0]     pin_s;
   logic [NUM_PORTS-1:0] pend_d;
   logic [NUM_PORTS-1:0] pend_q;
   logic                 irq_q;

   pcirq_sync #(
      .WIDTH   (TOT_W),
      .STAGES  (SYNC_STAGES),
      .RST_LVL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         pcirq_port_cmp #(
            .WIDTH (PORT_W)
         ) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_s_i  (pin_s[p*PORT_W +: PORT_W]),
            .snap_i   (snap_i[p*PORT_W +: PORT_W]),
            .dir_i    (dir_in_i[p*PORT_W +: PORT_W]),
            .rd_i     (rd_stb_i[p]),
            .pend_d_o (pend_d[p]),
            .pend_q_o (pend_q[p])
         );
      end
   endgenerate

   // registered so the line never sees a combinational glitch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend_d;
   end

   assign irq_pull_o = irq_q;

   // R8: the line is pulled exactly while some port holds a pending flag
   p_line_tracks_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pull_o == (|pend_q));

   // R5: a read of only some ports keeps the line pulled if an unread port was pending and still differs
   p_other_port_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~rd_stb_i & pend_d) != '0) |=> irq_pull_o);
endmodule

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
   localparam int unsigned PW = 8;
   localparam int unsigned NP = 2;
   localparam int unsigned SS = 2;
   localparam int unsigned TW = PW * NP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] pin = '1;
   logic [TW-1:0] dir = '1;
   logic [TW-1:0] snap = '1;
   logic [NP-1:0] rd = '0;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pin_change_irq #(.PORT_W(PW), .NUM_PORTS(NP), .SYNC_STAGES(SS)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin),
      .dir_in_i   (dir),
      .snap_i     (snap),
      .rd_stb_i   (rd),
      .irq_pull_o (irq)
   );

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: irq_pull_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // put everything back to a quiet, matched state
   task automatic settle();
      pin = '1; snap = '1; dir = '1; rd = '0;
      step(SS + 2);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      step(2);
      check("R1 during reset", irq, 1'b0);
      rst_n = 1'b1;
      step(1);
      check("R1 after release", irq, 1'b0);
   endtask

   task automatic t_raise_revert();
      settle();
      pin[3] = 1'b0;
      step(SS);
      check("R2 not before latency", irq, 1'b0);
      step(1);
      check("R2 mismatch port0", irq, 1'b1);
      check("R8 pulled while pending", irq, 1'b1);
      pin[3] = 1'b1;
      step(SS + 1);
      check("R3 revert clears", irq, 1'b0);
      pin[12] = 1'b0;
      step(SS + 1);
      check("R2 mismatch port1", irq, 1'b1);
      pin[12] = 1'b1;
      step(SS + 1);
      check("R3 revert port1", irq, 1'b0);
   endtask

   task automatic t_read_clear();
      settle();
      pin[0] = 1'b0;
      step(SS + 1);
      check("R2 pre-read", irq, 1'b1);
      rd[0] = 1'b1;
      step(1);
      rd[0] = 1'b0;
      snap[0] = 1'b0;
      check("R4 read clears port0", irq, 1'b0);
      step(2);
      check("R4 stays clear", irq, 1'b0);
   endtask

   task automatic t_cross_port();
      settle();
      pin[5] = 1'b0;
      pin[9] = 1'b0;
      step(SS + 1);
      check("R2 both pending", irq, 1'b1);
      rd[0] = 1'b1;
      step(1);
      rd[0] = 1'b0;
      snap[5] = 1'b0;
      check("R5 port1 survives port0 read", irq, 1'b1);
      rd[1] = 1'b1;
      step(1);
      rd[1] = 1'b0;
      snap[9] = 1'b0;
      check("R4 port1 read clears", irq, 1'b0);
      settle();
      pin[14] = 1'b0;
      pin[2] = 1'b0;
      step(SS + 1);
      rd[1] = 1'b1;
      step(1);
      rd[1] = 1'b0;
      snap[14] = 1'b0;
      check("R5 port0 survives port1 read", irq, 1'b1);
   endtask

   task automatic t_output_mask();
      settle();
      dir = 16'h00FF;
      step(1);
      for (int k = 0; k < 4; k++) begin
         pin[15:8] = 8'h5A ^ 8'(k * 37);
         step(SS + 1);
         check("R6 output pins silent", irq, 1'b0);
      end
   endtask

   task automatic t_dir_switch();
      settle();
      dir[1] = 1'b0;
      step(1);
      pin[1] = 1'b0;
      step(SS + 2);
      check("R6 output mismatch ignored", irq, 1'b0);
      dir[1] = 1'b1;
      step(1);
      check("R7 switch to input raises", irq, 1'b1);
   endtask

   initial begin
      t_reset();
      t_raise_revert();
      t_read_clear();
      t_cross_port();
      t_output_mask();
      t_dir_switch();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule